// File: doc/BRIEF.md
# Integer Execute Unit with Status Flags and Branch Decision

This block is the integer execute stage of a small 32-bit core. It combines two register operands with one of four operations: addition, subtraction, bitwise AND or bitwise exclusive-OR. The operation is chosen by a function code. The result is combinational, so the core can write it back in the same cycle it is produced.

Three status bits are kept in a register: zero, sign and signed overflow. They are reloaded at a clock edge only when the core marks the current instruction as an operation that sets flags. At every other edge they keep their value.

A combinational branch decider reads the stored status bits together with a condition code presented on the same function-code input. It returns whether a jump with that condition is taken. Register-file access and next-address logic belong to the surrounding core.

Top module: `exec_flag_unit`

## Requirements
- R1: With fn_code[1:0] = 0, result equals opnd_b + opnd_a modulo 2^32.
- R2: With fn_code[1:0] = 1, result equals opnd_b - opnd_a modulo 2^32, that is, the first operand is subtracted from the second.
- R3: fn_code[1:0] = 2 gives opnd_b AND opnd_a, and fn_code[1:0] = 3 gives opnd_b XOR opnd_a. The operation uses only the two low code bits, so codes 4 to 15 behave like the code equal to their low two bits.
- R4: result follows the operand and code inputs within the same cycle, with no register in between.
- R5: At a rising clock edge with set_flags = 1, flag_z becomes 1 exactly when result is zero, and flag_s becomes result bit 31.
- R6: For an addition, flag_o loads 1 exactly when both operands have the same sign bit and the result's sign bit differs from it.
- R7: For a subtraction, flag_o loads 1 exactly when the operands differ in sign bit and the result's sign bit differs from that of opnd_b.
- R8: For AND and XOR, flag_o loads 0.
- R9: At an edge with set_flags = 0, all three flags keep their values whatever the operand and code inputs are.
- R10: While rst_n is low, the flags are flag_z = 1, flag_s = 0, flag_o = 0.
- R11: cond_true, by fn_code value: 0 gives 1 (always); 1 gives (S^O)|Z; 2 gives S^O; 3 gives Z; 4 gives !Z; 5 gives !(S^O); 6 gives !(S^O) & !Z; 7 to 15 give 0.
- R12: cond_true depends only on the stored flags and fn_code. It ignores the current operands and the result that is being produced but not yet stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 32 | First source operand (the one subtracted) |
| opnd_b | input | 32 | Second source operand (minuend, write-back target) |
| fn_code | input | 4 | Operation code or branch condition code |
| set_flags | input | 1 | Load the status flags at this edge |
| result | output | 32 | Combinational operation result |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| flag_o | output | 1 | Stored signed-overflow flag |
| cond_true | output | 1 | Branch condition outcome from the stored flags |

## Verification
The assertions assume that the operand, code and set_flags inputs are settled at each rising edge. They also assume that a loaded flag describes the result visible at that same edge. The bench therefore changes every input shortly after a rising edge and holds it for the whole cycle. The flag checks are gated by a one-cycle arming register. Because of it, the first edge after reset is not compared against values captured while reset was still asserted. The bench also leaves at least one full cycle between releasing reset and its first flag-setting operation.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_ALWAYS = 4'd0,
    CC_LE     = 4'd1,
    CC_LT     = 4'd2,
    CC_EQ     = 4'd3,
    CC_NE     = 4'd4,
    CC_GE     = 4'd5,
    CC_GT     = 4'd6
  } cond_e;

  typedef struct packed {
    logic z;
    logic s;
    logic o;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{z: 1'b1, s: 1'b0, o: 1'b0};

endpackage

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output flags_t       nxt
);
  localparam int MSB = W - 1;

  function automatic logic add_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] r);
    return (x[MSB] == y[MSB]) && (r[MSB] != y[MSB]);
  endfunction

  function automatic logic sub_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] r);
    return (x[MSB] != y[MSB]) && (r[MSB] != y[MSB]);
  endfunction

  logic ovf;

  always_comb begin
    unique case (op)
      OP_ADD: begin res = b + a; ovf = add_ovf(a, b, b + a); end
      OP_SUB: begin res = b - a; ovf = sub_ovf(a, b, b - a); end
      OP_AND: begin res = b & a; ovf = 1'b0; end
      default: begin res = b ^ a; ovf = 1'b0; end
    endcase
  end

  assign nxt.z = (res == '0);
  assign nxt.s = res[MSB];
  assign nxt.o = ovf;

endmodule

// File: rtl/exu_flags.sv
module exu_flags
  import exu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t nxt,
  output flags_t cur,
  output logic   armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= FLAGS_RESET;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (load) cur <= nxt;
    end
  end

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(load) |-> $stable(cur));

endmodule

// File: rtl/exu_cond.sv
module exu_cond
  import exu_pkg::*;
#(
  parameter int FN_W = 4
) (
  input  flags_t          fl,
  input  logic [FN_W-1:0] code,
  output logic            taken
);
  logic lt;
  assign lt = fl.s ^ fl.o;

  always_comb begin
    case (code)
      FN_W'(CC_ALWAYS): taken = 1'b1;
      FN_W'(CC_LE):     taken = lt | fl.z;
      FN_W'(CC_LT):     taken = lt;
      FN_W'(CC_EQ):     taken = fl.z;
      FN_W'(CC_NE):     taken = !fl.z;
      FN_W'(CC_GE):     taken = !lt;
      FN_W'(CC_GT):     taken = !lt && !fl.z;
      default:          taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/exec_flag_unit.sv
module exec_flag_unit
  import exu_pkg::*;
#(
  parameter int W    = 32,
  parameter int FN_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [FN_W-1:0] fn_code,
  input  logic            set_flags,
  output logic [W-1:0]    result,
  output logic            flag_z,
  output logic            flag_s,
  output logic            flag_o,
  output logic            cond_true
);
  localparam int MSB = W - 1;

  alu_op_e op_sel;
  flags_t  flags_nxt;
  flags_t  flags_cur;
  logic    chk_armed;

  assign op_sel = alu_op_e'(fn_code[1:0]);

  exu_alu #(.W(W)) u_alu (
    .a   (opnd_a),
    .b   (opnd_b),
    .op  (op_sel),
    .res (result),
    .nxt (flags_nxt)
  );

  exu_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (set_flags),
    .nxt   (flags_nxt),
    .cur   (flags_cur),
    .armed (chk_armed)
  );

  exu_cond #(.FN_W(FN_W)) u_cond (
    .fl    (flags_cur),
    .code  (fn_code),
    .taken (cond_true)
  );

  assign flag_z = flags_cur.z;
  assign flag_s = flags_cur.s;
  assign flag_o = flags_cur.o;

  // R5
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed && $past(set_flags) |-> flag_z == ($past(result) == '0));

  // R5
  sign_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed && $past(set_flags) |-> flag_s == $past(result[MSB]));

  // R8
  logic_ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed && $past(set_flags) && $past(fn_code[1]) |-> !flag_o);

  // R12
  eq_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed && $past(set_flags) && ($past(result) == '0) && (fn_code == FN_W'(3))
      |-> cond_true);

endmodule

// File: tb/sim_exec_flag_unit.sv
module sim_exec_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]  fn_code = '0;
  logic        set_flags = 1'b0;
  logic [31:0] result;
  logic        flag_z, flag_s, flag_o, cond_true;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  exec_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .fn_code(fn_code), .set_flags(set_flags), .result(result),
    .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o), .cond_true(cond_true)
  );

  typedef struct {
    logic [31:0] res;
    logic        cnd;
    logic [2:0]  zso;
    string       tag;
  } item_t;

  item_t sb[$];
  logic [2:0] m_zso = 3'b100;

  function automatic logic model_cond(input logic [3:0] c, input logic [2:0] f);
    logic z, s, o;
    z = f[2]; s = f[1]; o = f[0];
    if (c == 4'd0) return 1'b1;
    if (c == 4'd1) return (s != o) || z;
    if (c == 4'd2) return s != o;
    if (c == 4'd3) return z;
    if (c == 4'd4) return !z;
    if (c == 4'd5) return s == o;
    if (c == 4'd6) return (s == o) && !z;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [3:0] fn,
                       input logic sf, input string tag);
    item_t it;
    logic signed [32:0] wide;
    logic [31:0] r;
    logic ov;
    case (fn % 4)
      0: begin wide = $signed({b[31], b}) + $signed({a[31], a}); ov = wide[32] ^ wide[31]; end
      1: begin wide = $signed({b[31], b}) - $signed({a[31], a}); ov = wide[32] ^ wide[31]; end
      2: begin wide = {1'b0, b & a}; ov = 1'b0; end
      default: begin wide = {1'b0, ~(~b ^ a)}; ov = 1'b0; end
    endcase
    r = wide[31:0];
    @(posedge clk); #1;
    opnd_a = a; opnd_b = b; fn_code = fn; set_flags = sf;
    it.res = r;
    it.cnd = model_cond(fn, m_zso);
    it.zso = m_zso;
    it.tag = tag;
    sb.push_back(it);
    if (sf) m_zso = {r == 32'd0, r[31], ov};
  endtask

  // monitor: at each falling edge compare the pending scoreboard item
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check({it.tag, " result"}, result, it.res);
      check({it.tag, " cond R11"}, {31'd0, cond_true}, {31'd0, it.cnd});
      check({it.tag, " flags zso"}, {29'd0, flag_z, flag_s, flag_o}, {29'd0, it.zso});
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R10 reset state
    check("R10 reset flags", {29'd0, flag_z, flag_s, flag_o}, 32'd4);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk);

    drive(32'd5, 32'd7, 4'd0, 1'b1, "R1 R4 add small");
    drive(32'd1, 32'h7fffffff, 4'd0, 1'b1, "R6 add pos ovf");
    drive(32'hffffffff, 32'd1, 4'd0, 1'b1, "R5 R6 add to zero");
    drive(32'h80000000, 32'h80000000, 4'd0, 1'b1, "R6 add neg ovf");
    drive(32'd3, 32'd10, 4'd1, 1'b1, "R2 sub b-a");
    drive(32'd1, 32'h80000000, 4'd1, 1'b1, "R7 sub ovf");
    drive(32'h12345678, 32'h12345678, 4'd1, 1'b1, "R2 R5 sub equal");
    drive(32'd5, 32'd2, 4'd1, 1'b1, "R2 R5 sub negative");
    drive(32'hffffffff, 32'h7ffffffe, 4'd1, 1'b1, "R7 sub no ovf mixed");
    drive(32'hf0f0ff00, 32'h0ff0f0f0, 4'd2, 1'b1, "R3 and");
    drive(32'd1, 32'h7fffffff, 4'd0, 1'b1, "R6 set ovf again");
    drive(32'h80000001, 32'h00000001, 4'd3, 1'b1, "R3 R8 xor clears O");
    drive(32'd1, 32'h7fffffff, 4'd0, 1'b1, "R6 set ovf third");
    drive(32'hffff0000, 32'h8000ffff, 4'd2, 1'b1, "R8 and clears O");
    drive(32'd4, 32'd9, 4'd5, 1'b1, "R3 code 5 acts as sub");
    drive(32'h0000ffff, 32'h00ff00ff, 4'd14, 1'b1, "R3 code 14 acts as and");
    drive(32'hdead0000, 32'h0000beef, 4'd0, 1'b0, "R9 add no load");
    drive(32'd0, 32'd0, 4'd3, 1'b0, "R9 R12 zero result unstored");
    drive(32'd7, 32'd7, 4'd1, 1'b1, "R5 store zero");
    drive(32'h11111111, 32'h22222222, 4'd3, 1'b0, "R12 eq ignores operands");
    drive(32'h11111111, 32'h22222222, 4'd4, 1'b0, "R12 ne ignores operands");
    // R11 sweep all condition codes under several stored flag states
    for (int k = 0; k < 16; k++) drive(32'd9, 32'd1, 4'(k), 1'b0, "R11 sweep z");
    drive(32'd5, 32'd2, 4'd1, 1'b1, "R11 load neg");
    for (int k = 0; k < 16; k++) drive(32'd0, 32'd0, 4'(k), 1'b0, "R11 sweep s");
    drive(32'd1, 32'h80000000, 4'd1, 1'b1, "R11 load pos ovf");
    for (int k = 0; k < 16; k++) drive(32'd3, 32'd3, 4'(k), 1'b0, "R11 sweep o");
    drive(32'd1, 32'd2, 4'd0, 1'b1, "R11 load pos");
    for (int k = 0; k < 16; k++) drive(32'd3, 32'd4, 4'(k), 1'b0, "R11 sweep gt");
    drive(32'd0, 32'd0, 4'd8, 1'b0, "R9 final hold");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule